// File: doc/BRIEF.md
# Text raster renderer

This block turns a screen of character codes into a one-bit pixel stream for a raster display. The screen is a grid of 80 columns by 40 rows, and each character cell is 8 pixels wide and 12 lines tall. The renderer runs on the pixel clock. It takes the line-end and frame-end strobes and the blank level from an external sync generator, and from those it keeps its own glyph-line, row and column counters.

For each cell it reads a 7-bit character code from an external synchronous text memory. It then reads one 8-bit glyph row from an external synchronous font memory that holds 128 glyphs. It shifts that row out most significant bit first. The fetch for the next cell starts while the current cell is still being shown. The fetch for column 0 starts during horizontal blanking. Both memory stages are therefore hidden, and every cell, the first one included, starts on the correct pixel.

Top module: `text_raster`

## Requirements
- R1: While reset is held and just after it is released, `pix` is 0. All counters start at glyph line 0, row 0, column 0.
- R2: In active cycle k of a visible line (k counted from the cycle in which `blank` falls), `pix` equals bit (7 - k mod 8) of the glyph row for the cell in column k/8. The most significant bit of the glyph row is shown first.
- R3: The text address is row*COLS + column. The 7-bit code returned one clock later selects the glyph. Changing the memory contents between frames changes the picture.
- R4: The font address is code*12 + glyph line. The 8-bit row returned one clock later is the one shown, including glyph line 11.
- R5: `pix` is 0 in every cycle in which `blank` is 1, whatever the shift register holds.
- R6: Each `line_end` advances the glyph line. After glyph line 11 the glyph line returns to 0 and the row advances. After row ROWS-1 the row returns to 0 even if no frame-end strobe arrives.
- R7: A `frame_end` that arrives together with `line_end` makes the next line show glyph line 0 of row 0. This holds even when the frame is cut short in the middle of the screen.
- R8: The first pixel of column 0 is correct on every line, provided at least six blank cycles pass between `line_end` and the first active cycle.
- R9: The last column (COLS-1) of every line is shown in full and correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | One-cycle strobe at the end of each scan line, during blanking |
| frame_end | input | 1 | One-cycle strobe, only together with `line_end`, on the last line of a frame |
| blank | input | 1 | High outside the active picture |
| txt_addr | output | clog2(COLS*ROWS) | Text memory address |
| txt_code | input | 7 | Character code read from `txt_addr` on the previous clock |
| font_addr | output | clog2(128*GH) | Font memory address |
| font_row | input | 8 | Glyph row read from `font_addr` on the previous clock |
| pix | output | 1 | Serial pixel output |

## Verification
The assertions assume the following about the inputs. `line_end` is a single-cycle strobe that falls inside blanking. `frame_end` is never high without `line_end`. At least six blank cycles separate `line_end` from the next active cycle. Each active stretch lasts exactly COLS*8 cycles, so cell fetches stay eight cycles apart and never overlap in the pipeline. The stimulus builds every line as 48 active cycles followed by 16 blank cycles, with `line_end` in the first blank cycle, and raises `frame_end` only on that same cycle. The frames vary in length: full frames, frames that run past the last row, and a frame that is cut short.

// File: rtl/txt_pkg.sv
package txt_pkg;
  localparam int DEF_COLS    = 80;
  localparam int DEF_ROWS    = 40;
  localparam int DEF_GLYPH_W = 8;
  localparam int DEF_GLYPH_H = 12;
  localparam int CODE_W      = 7;
  localparam int FONT_GLYPHS = 1 << CODE_W;
endpackage

// File: rtl/txt_scan_ctr.sv
module txt_scan_ctr #(
  parameter int COLS = txt_pkg::DEF_COLS,
  parameter int ROWS = txt_pkg::DEF_ROWS,
  parameter int GW   = txt_pkg::DEF_GLYPH_W,
  parameter int GH   = txt_pkg::DEF_GLYPH_H,
  localparam int CLW = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int GLW = $clog2(GH),
  localparam int PXW = $clog2(GW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_end,
  input  logic           frame_end,
  input  logic           blank,
  output logic [GLW-1:0] gline,
  output logic [RW-1:0]  row,
  output logic           req,
  output logic [CLW-1:0] req_col,
  output logic           px_last
);
  logic [GLW-1:0] gline_q, gline_d;
  logic [RW-1:0]  row_q, row_d;
  logic [CLW-1:0] col_q, col_d;
  logic [PXW-1:0] px_q, px_d;
  logic           ls_q;

  always_comb begin
    px_last = (px_q == PXW'(GW - 1));
    req     = ls_q | (~blank & (px_q == '0) & (col_q != CLW'(COLS - 1)));
    req_col = ls_q ? '0 : col_q + CLW'(1);
    px_d    = (blank | px_last) ? '0 : px_q + PXW'(1);
    col_d   = line_end ? '0 : (req ? req_col : col_q);
    gline_d = gline_q;
    row_d   = row_q;
    if (line_end) begin
      if (frame_end) begin
        gline_d = '0;
        row_d   = '0;
      end else if (gline_q == GLW'(GH - 1)) begin
        gline_d = '0;
        row_d   = (row_q == RW'(ROWS - 1)) ? '0 : row_q + RW'(1);
      end else begin
        gline_d = gline_q + GLW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gline_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
      px_q    <= '0;
      ls_q    <= 1'b0;
    end else begin
      gline_q <= gline_d;
      row_q   <= row_d;
      col_q   <= col_d;
      px_q    <= px_d;
      ls_q    <= line_end;
    end
  end

  assign gline = gline_q;
  assign row   = row_q;

  // R6
  gline_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gline_q) < GH);
  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_q) < ROWS);
  // R7
  frame_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && frame_end) |=> (gline_q == '0 && row_q == '0));
endmodule

// File: rtl/txt_fetch_pipe.sv
module txt_fetch_pipe #(
  parameter int COLS = txt_pkg::DEF_COLS,
  parameter int ROWS = txt_pkg::DEF_ROWS,
  parameter int GW   = txt_pkg::DEF_GLYPH_W,
  parameter int GH   = txt_pkg::DEF_GLYPH_H,
  localparam int CLW = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int GLW = $clog2(GH),
  localparam int TAW = $clog2(COLS * ROWS),
  localparam int FAW = $clog2(txt_pkg::FONT_GLYPHS * GH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic [CLW-1:0]             req_col,
  input  logic [RW-1:0]              row,
  input  logic [GLW-1:0]             gline,
  input  logic [txt_pkg::CODE_W-1:0] txt_code,
  input  logic [GW-1:0]              font_row,
  output logic [TAW-1:0]             txt_addr,
  output logic [FAW-1:0]             font_addr,
  output logic [GW-1:0]              glyph
);
  logic [TAW-1:0] addr_q, addr_d;
  logic [GW-1:0]  nxt_q, nxt_d;
  logic           rq_q, bv_q, fv_q;

  always_comb begin
    addr_d    = req ? (TAW'(row) * TAW'(COLS) + TAW'(req_col)) : addr_q;
    nxt_d     = fv_q ? font_row : nxt_q;
    font_addr = FAW'(txt_code) * FAW'(GH) + FAW'(gline);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      nxt_q  <= '0;
      rq_q   <= 1'b0;
      bv_q   <= 1'b0;
      fv_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      nxt_q  <= nxt_d;
      rq_q   <= req;
      bv_q   <= rq_q;
      fv_q   <= bv_q;
    end
  end

  assign txt_addr = addr_q;
  assign glyph    = nxt_q;

  // R3
  txt_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_q |-> (int'(txt_addr) < COLS * ROWS));
  // R4
  font_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> (int'(font_addr) < txt_pkg::FONT_GLYPHS * GH));
  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_q |-> !bv_q);
endmodule

// File: rtl/txt_shifter.sv
module txt_shifter #(
  parameter int GW = txt_pkg::DEF_GLYPH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          px_last,
  input  logic [GW-1:0] glyph,
  output logic          pix
);
  logic [GW-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = (blank | px_last) ? glyph : {sh_q[GW-2:0], 1'b0};
    pix  = ~blank & sh_q[GW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/text_raster.sv
module text_raster #(
  parameter int COLS = txt_pkg::DEF_COLS,
  parameter int ROWS = txt_pkg::DEF_ROWS,
  parameter int GW   = txt_pkg::DEF_GLYPH_W,
  parameter int GH   = txt_pkg::DEF_GLYPH_H,
  localparam int TAW = $clog2(COLS * ROWS),
  localparam int FAW = $clog2(txt_pkg::FONT_GLYPHS * GH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_end,
  input  logic                       frame_end,
  input  logic                       blank,
  output logic [TAW-1:0]             txt_addr,
  input  logic [txt_pkg::CODE_W-1:0] txt_code,
  output logic [FAW-1:0]             font_addr,
  input  logic [GW-1:0]              font_row,
  output logic                       pix
);
  localparam int CLW = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam int GLW = $clog2(GH);

  logic [GLW-1:0] gline;
  logic [RW-1:0]  row;
  logic           req;
  logic [CLW-1:0] req_col;
  logic           px_last;
  logic [GW-1:0]  glyph;

  txt_scan_ctr #(.COLS(COLS), .ROWS(ROWS), .GW(GW), .GH(GH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
    .blank(blank), .gline(gline), .row(row), .req(req), .req_col(req_col),
    .px_last(px_last)
  );

  txt_fetch_pipe #(.COLS(COLS), .ROWS(ROWS), .GW(GW), .GH(GH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .req(req), .req_col(req_col), .row(row),
    .gline(gline), .txt_code(txt_code), .font_row(font_row),
    .txt_addr(txt_addr), .font_addr(font_addr), .glyph(glyph)
  );

  txt_shifter #(.GW(GW)) u_shift (
    .clk(clk), .rst_n(rst_n), .blank(blank), .px_last(px_last),
    .glyph(glyph), .pix(pix)
  );
endmodule

// File: tb/tb_text_raster.sv
`timescale 1ns/1ps
module tb_text_raster;
  localparam int COLS = 6;
  localparam int ROWS = 3;
  localparam int GW   = 8;
  localparam int GH   = 12;
  localparam int ACT  = COLS * GW;
  localparam int BL   = 16;
  localparam int TAW  = $clog2(COLS * ROWS);
  localparam int FAW  = $clog2(128 * GH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           line_end = 1'b0;
  logic           frame_end = 1'b0;
  logic           blank = 1'b1;
  logic [TAW-1:0] txt_addr;
  logic [6:0]     txt_code;
  logic [FAW-1:0] font_addr;
  logic [GW-1:0]  font_row;
  logic           pix;

  int checks = 0;
  int errors = 0;
  int pat = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  text_raster #(.COLS(COLS), .ROWS(ROWS), .GW(GW), .GH(GH)) dut (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end),
    .blank(blank), .txt_addr(txt_addr), .txt_code(txt_code),
    .font_addr(font_addr), .font_row(font_row), .pix(pix)
  );

  function automatic logic [6:0] text_val(int a, int p);
    if (p == 0) return 7'((a * 13 + 5) % 128);
    return 7'(127 - (a * 7) % 128);
  endfunction

  function automatic logic [7:0] font_val(int a);
    int c = a / GH;
    int l = a % GH;
    return 8'(((c * 29) + (l * 53) + 1) ^ (c << 2));
  endfunction

  // Synchronous memories with one clock of read latency (R3, R4)
  always_ff @(posedge clk) begin
    txt_code <= text_val(int'(txt_addr), pat);
    font_row <= font_val(int'(font_addr));
  end

  task automatic check(bit exp, string tag);
    checks++;
    if (pix !== exp) begin
      errors++;
      $display("FAIL %s at %0t: pix actual %b expected %b", tag, $time, pix, exp);
    end
  endtask

  task automatic run_frame(int vis, int vb, int fidx);
    for (int ln = 0; ln < vis + vb; ln++) begin
      for (int c = 0; c < ACT + BL; c++) begin
        bit exp;
        string tag;
        @(posedge clk); #1;
        if (c == 0 && ln == vis && vb > 0) pat = fidx % 2;
        blank     = !(ln < vis && c < ACT);
        line_end  = (c == ACT);
        frame_end = (c == ACT) && (ln == vis + vb - 1);
        exp = 1'b0;
        tag = "R5";
        if (!blank) begin
          int row  = (ln / GH) % ROWS;
          int gl   = ln % GH;
          int col  = c / GW;
          int code = int'(text_val(row * COLS + col, pat));
          logic [7:0] b = font_val(code * GH + gl);
          exp = b[GW - 1 - (c % GW)];
          if (fidx == 3 && ln >= ROWS * GH)   tag = "R6";
          else if (fidx == 5 && ln < GH)      tag = "R7";
          else if (c == 0)                    tag = "R8";
          else if (col == COLS - 1)           tag = "R9";
          else if (gl == GH - 1)              tag = "R4";
          else if (pat == 1)                  tag = "R3";
          else                                tag = "R2";
        end
        @(negedge clk);
        check(exp, tag);
      end
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(1'b0, "R1");
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    run_frame(0, 1, 0);
    run_frame(ROWS * GH, 3, 1);
    run_frame(ROWS * GH, 3, 2);
    run_frame(2 * ROWS * GH, 3, 3);
    run_frame(20, 0, 4);
    run_frame(ROWS * GH, 2, 5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual still running, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule